// File: doc/BRIEF.md
# Tagged memory bridge with tag cache

The bridge connects a cache whose lines carry one tag bit per 64-bit word to a plain memory port that stores only untagged data. A line of four words arrives as 260 bits, each word followed by its tag bit. On a line write the bridge strips out the tag bits and writes the 256 data bits to the data region. It then merges the four tag bits into a small direct-mapped tag cache. On a line read it fetches the data words from the data region. The tag bits come from the tag cache, and on a tag-cache miss they come from a separate tag region in memory. The bridge then puts each tag bit back beside its word and returns the tagged line.

The tag region holds one 64-bit group per 16 consecutive lines, and a tag-cache entry holds exactly one such group. A miss evicts the entry at the same index. A dirty victim is written back to the tag region before the new group is fetched. The tag cache starts empty after reset, so the first accesses always fetch tags from memory. A tag hit never saves the data access: every request still reads or writes its data words in memory.

Requests are served one at a time. The cache-side port and the memory port both use valid/ready handshakes, and the memory answers each request, read or write, with a single response pulse.

Top module: `tagmem_bridge`

## Requirements
- R1: On a line write, the first memory request is a write to the line's data address. Its wdata carries word i of the line at bits [64i+63:64i], with all tag bits removed.
- R2: The data address of line A is A itself. The tag-group address of line A is TAG_BASE + (A >> 4), default 1024. A tag group sits in wdata/rdata bits [63:0], and line A's four tags sit at group bits [4*(A mod 16)+3 : 4*(A mod 16)], word 0 lowest.
- R3: A line read returns word i at up_rsp_line bits [65i+63:65i] and its tag at bit 65i+64. The words and tags are those of the last write to that line, or the memory contents if the line was never written.
- R4: After reset the tag cache holds nothing. The first access to any group is a data access followed by a tag-group read, and the returned tags are exactly those stored in the tag region.
- R5: An access whose group is present in the tag cache makes exactly one memory request, the data access.
- R6: When a miss lands on an entry whose group has been written (dirty), the bridge makes three requests in order. These are the data access, a write of the victim's full 64-bit group to the victim's tag address, and a read of the new group.
- R7: When a miss lands on an empty or clean entry, the bridge makes exactly two requests: the data access, then a read of the new group.
- R8: up_req_ready is low from acceptance until the response handshake. While a response or memory request is held off by its ready signal, its valid stays high and its content stays stable.
- R9: Every transaction, hit or miss, starts with its data access before any tag-region access.
- R10: The response to a line write carries an all-zero up_rsp_line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req_valid | input | 1 | Cache-side request valid |
| up_req_ready | output | 1 | Bridge can accept a request |
| up_req_write | input | 1 | 1 = line write, 0 = line read |
| up_req_addr | input | 10 | Line address |
| up_req_line | input | 260 | Tagged line to write (4 x {tag, word}) |
| up_rsp_valid | output | 1 | Response valid |
| up_rsp_ready | input | 1 | Cache side takes the response |
| up_rsp_line | output | 260 | Tagged line read, zero for writes |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = memory write |
| mem_req_addr | output | 11 | Memory address in 256-bit units |
| mem_req_wdata | output | 256 | Write data (tag groups in bits [63:0]) |
| mem_rsp_valid | input | 1 | One-cycle response pulse per request |
| mem_rsp_rdata | input | 256 | Read data |

## Verification
The assertions check the handshake rules on every cycle. Nothing new is accepted while a response is pending, and held responses and memory requests stay stable. They also check that each transaction's first memory request goes to the data region, that write responses are zero, and that a victim writeback is followed by a tag read and never by a second tag write. Only the bench scenarios can show end-to-end contents. These are tags surviving an eviction and coming back in the right word positions, the exact number and targets of memory requests per hit or miss, the written-back group value, and the loss of unwritten dirty tags across a reset.

// File: rtl/tagbr_pkg.sv
package tagbr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DREQ,
    ST_DRSP,
    ST_WBREQ,
    ST_WBRSP,
    ST_FREQ,
    ST_FRSP,
    ST_RESP
  } br_state_e;
endpackage

// File: rtl/tagbr_rstsync.sv
module tagbr_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/tagbr_split.sv
module tagbr_split #(
  parameter int WORDS  = 4,
  parameter int WORD_W = 64
) (
  input  logic [WORDS*(WORD_W+1)-1:0] tagged_in,
  output logic [WORDS*WORD_W-1:0]     plain_out,
  output logic [WORDS-1:0]            tags_out,
  input  logic [WORDS*WORD_W-1:0]     plain_in,
  input  logic [WORDS-1:0]            tags_in,
  output logic [WORDS*(WORD_W+1)-1:0] tagged_out
);
  localparam int SLOT_W = WORD_W + 1;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    // strip direction
    assign plain_out[w*WORD_W +: WORD_W] = tagged_in[w*SLOT_W +: WORD_W];
    assign tags_out[w]                   = tagged_in[w*SLOT_W + WORD_W];
    // insert direction
    assign tagged_out[w*SLOT_W +: SLOT_W] = {tags_in[w], plain_in[w*WORD_W +: WORD_W]};
  end
endmodule

// File: rtl/tagbr_tagcache.sv
module tagbr_tagcache #(
  parameter int ENTRIES = 16,
  parameter int GRP_W   = 6,
  parameter int GBITS   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GRP_W-1:0] lk_grp,
  output logic             lk_hit,
  output logic [GBITS-1:0] lk_bits,
  output logic             vic_dirty,
  output logic [GRP_W-1:0] vic_grp,
  input  logic             wr_en,
  input  logic             wr_dirty,
  input  logic [GBITS-1:0] wr_bits
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CT_W  = GRP_W - IDX_W;

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] dirty_q;
  logic [CT_W-1:0]    ctag_q [ENTRIES];
  logic [GBITS-1:0]   bits_q [ENTRIES];

  logic [IDX_W-1:0] idx;
  logic [CT_W-1:0]  ct;

  assign idx = lk_grp[IDX_W-1:0];
  assign ct  = lk_grp[GRP_W-1:IDX_W];

  assign lk_hit    = valid_q[idx] && (ctag_q[idx] == ct);
  assign lk_bits   = bits_q[idx];
  assign vic_dirty = valid_q[idx] && dirty_q[idx] && !lk_hit;
  assign vic_grp   = {ctag_q[idx], idx};

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic sel;
    assign sel = wr_en && (idx == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[e] <= 1'b0;
        dirty_q[e] <= 1'b0;
      end else if (sel) begin
        valid_q[e] <= 1'b1;
        dirty_q[e] <= wr_dirty;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        ctag_q[e] <= ct;
        bits_q[e] <= wr_bits;
      end
    end
  end
endmodule

// File: rtl/tagbr_ctrl.sv
module tagbr_ctrl
  import tagbr_pkg::*;
#(
  parameter int LINE_AW  = 10,
  parameter int WORDS    = 4,
  parameter int LINE_W   = 256,
  parameter int GBITS    = 64,
  parameter int OFF_W    = 4,
  parameter int GRP_W    = 6,
  parameter int MEM_AW   = 11,
  parameter int TAG_BASE = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               up_req_valid,
  output logic               up_req_ready,
  input  logic               up_req_write,
  input  logic [LINE_AW-1:0] up_req_addr,
  input  logic [LINE_W-1:0]  req_plain,
  input  logic [WORDS-1:0]   req_tags,
  output logic               up_rsp_valid,
  input  logic               up_rsp_ready,
  output logic [LINE_W-1:0]  rsp_plain,
  output logic [WORDS-1:0]   rsp_tags,
  output logic               rsp_is_write,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [MEM_AW-1:0]  mem_req_addr,
  output logic [LINE_W-1:0]  mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [LINE_W-1:0]  mem_rsp_rdata,
  output logic [GRP_W-1:0]   lk_grp,
  input  logic               lk_hit,
  input  logic [GBITS-1:0]   lk_bits,
  input  logic               vic_dirty,
  input  logic [GRP_W-1:0]   vic_grp,
  output logic               tc_wr_en,
  output logic               tc_wr_dirty,
  output logic [GBITS-1:0]   tc_wr_bits
);
  localparam logic [MEM_AW-1:0] TBASE = MEM_AW'(TAG_BASE);

  br_state_e          st_q, st_d;
  logic               wr_q;
  logic [LINE_AW-1:0] addr_q;
  logic [LINE_W-1:0]  data_q;
  logic [WORDS-1:0]   tags_q;
  logic [OFF_W-1:0]   off;
  logic               req_ld, rd_ld;

  assign off    = addr_q[OFF_W-1:0];
  assign lk_grp = addr_q[LINE_AW-1:OFF_W];

  function automatic logic [GBITS-1:0] merge_tags(input logic [GBITS-1:0] base,
                                                  input logic [OFF_W-1:0] pos,
                                                  input logic [WORDS-1:0] t);
    logic [GBITS-1:0] r;
    r = base;
    r[int'(pos)*WORDS +: WORDS] = t;
    return r;
  endfunction

  // next state and tag-cache update
  always_comb begin
    st_d        = st_q;
    tc_wr_en    = 1'b0;
    tc_wr_dirty = 1'b0;
    tc_wr_bits  = lk_bits;
    unique case (st_q)
      ST_IDLE:  if (up_req_valid) st_d = ST_DREQ;
      ST_DREQ:  if (mem_req_ready) st_d = ST_DRSP;
      ST_DRSP: begin
        if (mem_rsp_valid) begin
          if (lk_hit) begin
            if (wr_q) begin
              tc_wr_en    = 1'b1;
              tc_wr_dirty = 1'b1;
              tc_wr_bits  = merge_tags(lk_bits, off, tags_q);
            end
            st_d = ST_RESP;
          end else if (vic_dirty) begin
            st_d = ST_WBREQ;
          end else begin
            st_d = ST_FREQ;
          end
        end
      end
      ST_WBREQ: if (mem_req_ready) st_d = ST_WBRSP;
      ST_WBRSP: if (mem_rsp_valid) st_d = ST_FREQ;
      ST_FREQ:  if (mem_req_ready) st_d = ST_FRSP;
      ST_FRSP: begin
        if (mem_rsp_valid) begin
          tc_wr_en    = 1'b1;
          tc_wr_dirty = wr_q;
          tc_wr_bits  = wr_q ? merge_tags(mem_rsp_rdata[GBITS-1:0], off, tags_q)
                             : mem_rsp_rdata[GBITS-1:0];
          st_d = ST_RESP;
        end
      end
      ST_RESP:  if (up_rsp_ready) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // output decode
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = '0;
    mem_req_wdata = '0;
    unique case (st_q)
      ST_DREQ: begin
        mem_req_valid = 1'b1;
        mem_req_write = wr_q;
        mem_req_addr  = MEM_AW'(addr_q);
        mem_req_wdata = wr_q ? data_q : '0;
      end
      ST_WBREQ: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = TBASE + MEM_AW'(vic_grp);
        mem_req_wdata = LINE_W'(lk_bits);
      end
      ST_FREQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = TBASE + MEM_AW'(lk_grp);
      end
      default: ;
    endcase
  end

  assign up_req_ready = (st_q == ST_IDLE);
  assign up_rsp_valid = (st_q == ST_RESP);
  assign rsp_plain    = data_q;
  assign rsp_tags     = lk_bits[int'(off)*WORDS +: WORDS];
  assign rsp_is_write = wr_q;

  assign req_ld = (st_q == ST_IDLE) && up_req_valid;
  assign rd_ld  = (st_q == ST_DRSP) && mem_rsp_valid && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      wr_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (req_ld) wr_q <= up_req_write;
    end
  end

  always_ff @(posedge clk) begin
    if (req_ld) begin
      addr_q <= up_req_addr;
      tags_q <= req_tags;
    end
    if (req_ld)      data_q <= req_plain;
    else if (rd_ld)  data_q <= mem_rsp_rdata;
  end
endmodule

// File: rtl/tagmem_bridge.sv
module tagmem_bridge #(
  parameter int WORDS       = 4,
  parameter int WORD_W      = 64,
  parameter int LINE_AW     = 10,
  parameter int GROUP_LINES = 16,
  parameter int TC_ENTRIES  = 16,
  parameter int MEM_AW      = 11,
  parameter int TAG_BASE    = 1024
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         up_req_valid,
  output logic                         up_req_ready,
  input  logic                         up_req_write,
  input  logic [LINE_AW-1:0]           up_req_addr,
  input  logic [WORDS*(WORD_W+1)-1:0]  up_req_line,
  output logic                         up_rsp_valid,
  input  logic                         up_rsp_ready,
  output logic [WORDS*(WORD_W+1)-1:0]  up_rsp_line,
  output logic                         mem_req_valid,
  input  logic                         mem_req_ready,
  output logic                         mem_req_write,
  output logic [MEM_AW-1:0]            mem_req_addr,
  output logic [WORDS*WORD_W-1:0]      mem_req_wdata,
  input  logic                         mem_rsp_valid,
  input  logic [WORDS*WORD_W-1:0]      mem_rsp_rdata
);
  localparam int LINE_W  = WORDS * WORD_W;
  localparam int TLINE_W = WORDS * (WORD_W + 1);
  localparam int OFF_W   = $clog2(GROUP_LINES);
  localparam int GRP_W   = LINE_AW - OFF_W;
  localparam int GBITS   = GROUP_LINES * WORDS;

  logic               rst_n_sync;
  logic [LINE_W-1:0]  req_plain, rsp_plain;
  logic [WORDS-1:0]   req_tags, rsp_tags;
  logic [TLINE_W-1:0] rsp_tagged;
  logic               rsp_is_write;
  logic [GRP_W-1:0]   lk_grp, vic_grp;
  logic               lk_hit, vic_dirty;
  logic [GBITS-1:0]   lk_bits, tc_wr_bits;
  logic               tc_wr_en, tc_wr_dirty;

  tagbr_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  tagbr_split #(.WORDS(WORDS), .WORD_W(WORD_W)) u_split (
    .tagged_in  (up_req_line),
    .plain_out  (req_plain),
    .tags_out   (req_tags),
    .plain_in   (rsp_plain),
    .tags_in    (rsp_tags),
    .tagged_out (rsp_tagged)
  );

  tagbr_tagcache #(.ENTRIES(TC_ENTRIES), .GRP_W(GRP_W), .GBITS(GBITS)) u_tc (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .lk_grp    (lk_grp),
    .lk_hit    (lk_hit),
    .lk_bits   (lk_bits),
    .vic_dirty (vic_dirty),
    .vic_grp   (vic_grp),
    .wr_en     (tc_wr_en),
    .wr_dirty  (tc_wr_dirty),
    .wr_bits   (tc_wr_bits)
  );

  tagbr_ctrl #(
    .LINE_AW(LINE_AW), .WORDS(WORDS), .LINE_W(LINE_W), .GBITS(GBITS),
    .OFF_W(OFF_W), .GRP_W(GRP_W), .MEM_AW(MEM_AW), .TAG_BASE(TAG_BASE)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n_sync),
    .up_req_valid  (up_req_valid),
    .up_req_ready  (up_req_ready),
    .up_req_write  (up_req_write),
    .up_req_addr   (up_req_addr),
    .req_plain     (req_plain),
    .req_tags      (req_tags),
    .up_rsp_valid  (up_rsp_valid),
    .up_rsp_ready  (up_rsp_ready),
    .rsp_plain     (rsp_plain),
    .rsp_tags      (rsp_tags),
    .rsp_is_write  (rsp_is_write),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata),
    .lk_grp        (lk_grp),
    .lk_hit        (lk_hit),
    .lk_bits       (lk_bits),
    .vic_dirty     (vic_dirty),
    .vic_grp       (vic_grp),
    .tc_wr_en      (tc_wr_en),
    .tc_wr_dirty   (tc_wr_dirty),
    .tc_wr_bits    (tc_wr_bits)
  );

  assign up_rsp_line = rsp_is_write ? '0 : rsp_tagged;
endmodule

// File: rtl/tagbr_chk.sv
module tagbr_chk #(
  parameter int TLINE_W  = 260,
  parameter int LINE_W   = 256,
  parameter int MEM_AW   = 11,
  parameter int TAG_BASE = 1024
) (
  input logic               clk,
  input logic               rst_n,
  input logic               up_req_valid,
  input logic               up_req_ready,
  input logic               up_req_write,
  input logic               up_rsp_valid,
  input logic               up_rsp_ready,
  input logic [TLINE_W-1:0] up_rsp_line,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic               mem_req_write,
  input logic [MEM_AW-1:0]  mem_req_addr,
  input logic [LINE_W-1:0]  mem_req_wdata
);
  localparam logic [MEM_AW-1:0] TBASE = MEM_AW'(TAG_BASE);

  logic txn_wr, first_pend, tagwr_seen;
  logic mem_hs, up_hs, tag_hs;

  assign mem_hs = mem_req_valid && mem_req_ready;
  assign up_hs  = up_req_valid && up_req_ready;
  assign tag_hs = mem_hs && (mem_req_addr >= TBASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txn_wr     <= 1'b0;
      first_pend <= 1'b0;
      tagwr_seen <= 1'b0;
    end else if (up_hs) begin
      txn_wr     <= up_req_write;
      first_pend <= 1'b1;
      tagwr_seen <= 1'b0;
    end else begin
      if (mem_hs) first_pend <= 1'b0;
      if (tag_hs && mem_req_write) tagwr_seen <= 1'b1;
    end
  end

  // R9
  first_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_pend && mem_hs) |-> (mem_req_addr < TBASE));

  // R8
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_rsp_valid |-> !up_req_ready);

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid && !up_rsp_ready) |=> (up_rsp_valid && $stable(up_rsp_line)));

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) &&
       $stable(mem_req_wdata)));

  // R10
  wr_rsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rsp_valid && txn_wr) |-> (up_rsp_line == '0));

  // R6
  wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_hs && tagwr_seen) |-> !mem_req_write);
endmodule

bind tagmem_bridge tagbr_chk #(
  .TLINE_W(TLINE_W), .LINE_W(LINE_W), .MEM_AW(MEM_AW), .TAG_BASE(TAG_BASE)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .up_req_valid  (up_req_valid),
  .up_req_ready  (up_req_ready),
  .up_req_write  (up_req_write),
  .up_rsp_valid  (up_rsp_valid),
  .up_rsp_ready  (up_rsp_ready),
  .up_rsp_line   (up_rsp_line),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata)
);

// File: tb/tb_tagmem_bridge.sv
module tb_tagmem_bridge;
  logic         clk;
  logic         rst_n;
  logic         up_req_valid, up_req_ready, up_req_write;
  logic [9:0]   up_req_addr;
  logic [259:0] up_req_line;
  logic         up_rsp_valid, up_rsp_ready;
  logic [259:0] up_rsp_line;
  logic         mem_req_valid, mem_req_ready, mem_req_write;
  logic [10:0]  mem_req_addr;
  logic [255:0] mem_req_wdata;
  logic         mem_rsp_valid;
  logic [255:0] mem_rsp_rdata;

  int checks = 0;
  int errors = 0;

  tagmem_bridge dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  // ---------------- memory model ----------------
  logic [255:0] mem [0:2047];
  logic [10:0]  log_addr [0:4095];
  logic         log_wr   [0:4095];
  int           op_idx;
  logic         m_pend, m_gate;
  int           m_dly;
  logic [15:0]  lfsr;

  assign mem_req_ready = !m_pend && m_gate;

  always @(posedge clk) begin
    lfsr          <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_gate        <= lfsr[3] | lfsr[7];
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      log_addr[op_idx] <= mem_req_addr;
      log_wr[op_idx]   <= mem_req_write;
      op_idx           <= op_idx + 1;
      if (mem_req_write) mem[mem_req_addr] <= mem_req_wdata;
      mem_rsp_rdata <= mem[mem_req_addr];
      m_pend        <= 1'b1;
      m_dly         <= int'(lfsr[1:0]);
    end else if (m_pend) begin
      if (m_dly == 0) begin
        mem_rsp_valid <= 1'b1;
        m_pend        <= 1'b0;
      end else begin
        m_dly <= m_dly - 1;
      end
    end
  end

  // ---------------- shadow state ----------------
  logic [255:0] sh_data [0:1023];
  logic [3:0]   sh_tag  [0:1023];
  logic         m_valid [0:15];
  logic         m_dirty [0:15];
  int           m_grp   [0:15];

  function automatic logic [255:0] mk_data(input int seed, input int addr);
    logic [255:0] d;
    for (int w = 0; w < 4; w++)
      d[w*64 +: 64] = {32'(seed * 7919 + w * 131), 32'(addr ^ (w << 20) ^ 32'h5A5A0000)};
    return d;
  endfunction

  function automatic logic [63:0] tpat(input int g);
    return 64'(g + 1) * 64'h9E3779B97F4A7C15;
  endfunction

  function automatic logic [259:0] pack(input logic [255:0] d, input logic [3:0] t);
    logic [259:0] l;
    for (int w = 0; w < 4; w++) l[w*65 +: 65] = {t[w], d[w*64 +: 64]};
    return l;
  endfunction

  function automatic logic [63:0] sgroup(input int g);
    logic [63:0] b;
    for (int l = 0; l < 16; l++) b[l*4 +: 4] = sh_tag[g*16 + l];
    return b;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [259:0] act, input logic [259:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 16; i++) m_valid[i] = 1'b0;
  endtask

  task automatic run_txn(input bit wr, input int addr, input logic [259:0] wline,
                         output logic [259:0] rline, output int nops, output int first);
    @(negedge clk);
    up_req_valid = 1'b1;
    up_req_write = wr;
    up_req_addr  = 10'(addr);
    up_req_line  = wline;
    while (!up_req_ready) @(negedge clk);
    first = op_idx;
    @(negedge clk);
    up_req_valid = 1'b0;
    while (!up_rsp_valid) @(negedge clk);
    rline = up_rsp_line;
    nops  = op_idx - first;
    @(negedge clk);
  endtask

  // full transaction with model-based expectations
  task automatic txn_checked(input bit wr, input int addr, input int seed);
    logic [259:0] wl, rl;
    logic [255:0] d;
    logic [3:0]   t;
    int g, ix, vg, exp_ops, nops, first;
    bit hit, vdirty;
    g  = addr >> 4;
    ix = g % 16;
    d  = mk_data(seed, addr);
    t  = 4'(seed ^ addr);
    wl = pack(d, t);
    hit    = m_valid[ix] && (m_grp[ix] == g);
    vdirty = m_valid[ix] && m_dirty[ix] && !hit;
    vg     = m_grp[ix];
    exp_ops = hit ? 1 : (vdirty ? 3 : 2);

    run_txn(wr, addr, wl, rl, nops, first);

    if (wr) begin
      sh_data[addr] = d;
      sh_tag[addr]  = t;
    end
    chk(nops == exp_ops, hit ? "R5" : (vdirty ? "R6" : "R7"), "memory request count",
        260'(nops), 260'(exp_ops));
    chk(log_addr[first] == 11'(addr) && log_wr[first] == wr, "R9", "first request is data access",
        260'({log_wr[first], log_addr[first]}), 260'({wr, 11'(addr)}));
    if (wr) begin
      chk(mem[addr] == d, "R1", "stripped data in memory", 260'(mem[addr]), 260'(d));
      chk(rl == '0, "R10", "write response zero", rl, 260'(0));
    end else begin
      chk(rl == pack(sh_data[addr], sh_tag[addr]), "R3", "tagged line read", rl,
          pack(sh_data[addr], sh_tag[addr]));
    end
    if (exp_ops == 3) begin
      chk(log_wr[first+1] && log_addr[first+1] == 11'(1024 + vg), "R6", "victim writeback target",
          260'({log_wr[first+1], log_addr[first+1]}), 260'({1'b1, 11'(1024 + vg)}));
      chk(mem[1024 + vg][63:0] == sgroup(vg), "R6", "written-back group value",
          260'(mem[1024 + vg][63:0]), 260'(sgroup(vg)));
      chk(!log_wr[first+2] && log_addr[first+2] == 11'(1024 + g), "R2", "fill after writeback",
          260'({log_wr[first+2], log_addr[first+2]}), 260'({1'b0, 11'(1024 + g)}));
    end else if (exp_ops == 2) begin
      chk(!log_wr[first+1] && log_addr[first+1] == 11'(1024 + g), "R2", "tag group read address",
          260'({log_wr[first+1], log_addr[first+1]}), 260'({1'b0, 11'(1024 + g)}));
    end
    m_dirty[ix] = hit ? (m_dirty[ix] | wr) : wr;
    m_valid[ix] = 1'b1;
    m_grp[ix]   = g;
  endtask

  typedef struct packed {
    logic       wr;
    logic [9:0] addr;
    logic [7:0] seed;
  } vec_t;

  localparam vec_t VEC [13] = '{
    '{1'b0, 10'h005, 8'd0},
    '{1'b1, 10'h005, 8'd11},
    '{1'b1, 10'h00A, 8'd22},
    '{1'b0, 10'h005, 8'd0},
    '{1'b0, 10'h105, 8'd0},
    '{1'b0, 10'h005, 8'd0},
    '{1'b0, 10'h00A, 8'd0},
    '{1'b1, 10'h213, 8'd33},
    '{1'b1, 10'h3F0, 8'd44},
    '{1'b0, 10'h213, 8'd0},
    '{1'b0, 10'h013, 8'd0},
    '{1'b0, 10'h213, 8'd0},
    '{1'b0, 10'h3F0, 8'd0}
  };

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [259:0] rl, held;
    int nops, first;
    bit stable_ok;
    rst_n = 1'b0;
    up_req_valid = 1'b0; up_req_write = 1'b0; up_req_addr = '0; up_req_line = '0;
    up_rsp_ready = 1'b1;
    lfsr = 16'hACE1; m_pend = 1'b0; m_gate = 1'b0; m_dly = 0; op_idx = 0;
    mem_rsp_valid = 1'b0; mem_rsp_rdata = '0;
    for (int a = 0; a < 1024; a++) begin
      mem[a]     = mk_data(1000 + a, a);
      sh_data[a] = mem[a];
    end
    for (int g = 0; g < 64; g++) mem[1024 + g] = {192'b0, tpat(g)};
    for (int a = 0; a < 1024; a++) sh_tag[a] = tpat(a >> 4)[(a % 16)*4 +: 4];
    for (int i = 0; i < 16; i++) begin m_valid[i] = 1'b0; m_dirty[i] = 1'b0; m_grp[i] = 0; end

    do_reset();
    // R4 reset state at the ports
    chk(up_req_ready && !up_rsp_valid && !mem_req_valid, "R4", "idle after reset",
        260'({up_req_ready, up_rsp_valid, mem_req_valid}), 260'(3'b100));

    for (int v = 0; v < 13; v++)
      txn_checked(VEC[v].wr, int'(VEC[v].addr), int'(VEC[v].seed));

    // R4: second reset drops the dirty group 63 without writing it back
    do_reset();
    run_txn(1'b0, 10'h3F0, '0, rl, nops, first);
    chk(nops == 2 && !log_wr[first+1] && log_addr[first+1] == 11'(1024 + 63), "R4",
        "compulsory tag fetch after reset", 260'(nops), 260'(2));
    chk(rl == pack(sh_data[10'h3F0], mem[1024 + 63][3:0]), "R4", "tags taken from tag region",
        rl, pack(sh_data[10'h3F0], mem[1024 + 63][3:0]));
    for (int a = 0; a < 1024; a++) sh_tag[a] = mem[1024 + (a >> 4)][(a % 16)*4 +: 4];
    m_valid[15] = 1'b1; m_dirty[15] = 1'b0; m_grp[15] = 63;

    // R8: response held while up_rsp_ready is low
    up_rsp_ready = 1'b0;
    @(negedge clk);
    up_req_valid = 1'b1; up_req_write = 1'b0; up_req_addr = 10'h3F1;
    while (!up_req_ready) @(negedge clk);
    @(negedge clk);
    up_req_valid = 1'b0;
    while (!up_rsp_valid) @(negedge clk);
    held = up_rsp_line;
    stable_ok = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (!up_rsp_valid || up_req_ready || up_rsp_line != held) stable_ok = 1'b0;
    end
    chk(stable_ok, "R8", "held response stable, no accept", 260'(stable_ok), 260'(1));
    chk(held == pack(sh_data[10'h3F1], sh_tag[10'h3F1]), "R3", "held line content", held,
        pack(sh_data[10'h3F1], sh_tag[10'h3F1]));
    up_rsp_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(up_req_ready && !up_rsp_valid, "R8", "ready again after handshake",
        260'({up_req_ready, up_rsp_valid}), 260'(2'b10));

    // write then read across an eviction of a dirty group (index 2)
    txn_checked(1'b1, 10'h02F, 77);
    txn_checked(1'b1, 10'h12F, 88);
    txn_checked(1'b0, 10'h02F, 0);
    txn_checked(1'b0, 10'h12F, 0);

    finish_run();
  end
endmodule